// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block chooses the 5-bit frequency-select code that a clock synthesizer uses, and it protects the system against a frequency setting that hangs it. While the active-low power-good input is asserted, five strap pins are sampled. Their value is frozen once power-good is released and stays readable as status. Software can replace the strap code with its own select code, or it can switch the synthesizer to direct M/N programming.

A watchdog counts down in units of a slow tick, nominally 250 ms. Software restarts it by writing its enable to 1, which acts as the keep-alive. If the count runs out, the block cancels M/N programming. It then falls back either to the frozen strap code or to a separately programmed safe code. When the mode strap is 1, it also drives a shared pin low for a fixed number of ticks as a system reset. When the mode strap is 0, the same pin carries an ordinary clock.

Top module: `wfg_guard`

## Requirements
- R1: While `pwr_ok_n` is 0, `strap_code` and the mode strap follow `strap_fs` and `strap_mode`. After `pwr_ok_n` has been 0 and then returns to 1, both hold their value until reset, whatever the strap pins do.
- R2: `fs_code` equals the stored software code when the stored select enable is 1, and equals `strap_code` when it is 0. A `cfg_we` pulse loads the select enable, the software code, the M/N enable, the safe-reload enable and the safe code.
- R3: A `wd_we` pulse with `wd_en_in`=1 loads the count from the stored depth, sets `wd_running` to 1 and clears `wd_timeout`. A `wd_we` pulse with `wd_en_in`=0 stops the count and leaves `wd_timeout` unchanged.
- R4: Each `tick` while running lowers the count by 1. `depth_rd` shows the live count while running and the stored depth (written by `depth_we`) otherwise.
- R5: A `tick` that arrives while running with a count of 0 or 1 ends the count: `wd_running` becomes 0 and `wd_timeout` becomes 1. As a result, depth 0 expires on the first tick and depth N expires on the N-th tick.
- R6: On expiry, `mn_mode` is cleared.
- R7: On expiry, if the safe-reload enable is 1, the software code becomes the safe code and the select enable is forced to 1. If the safe-reload enable is 0, the select enable is cleared, so `fs_code` returns to `strap_code`.
- R8: Expiry takes priority over a `cfg_we` in the same cycle, which is then lost. A `wd_we` takes priority over a `tick` in the same cycle.
- R9: With the mode strap at 1, `pin_oe`=1 and `pin_drv`=0 from expiry until `PULSE_TICKS` further ticks have passed, and `pin_oe`=0 otherwise. With the mode strap at 0, `pin_oe`=1 and `pin_drv` follows `clk_src`.
- R10: After reset: select enable 0, software code 5'b00010, safe code 5'b00010, depth 8, `mn_mode` 0, `wd_running` 0, `wd_timeout` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_n | input | 1 | Active-low power-good; straps are sampled while low |
| strap_fs | input | 5 | Frequency-select strap pins |
| strap_mode | input | 1 | Shared-pin function strap |
| tick | input | 1 | One-cycle pulse per watchdog count unit |
| cfg_we | input | 1 | Load the select and recovery settings |
| sel_en_in | input | 1 | Software select enable to store |
| sw_code_in | input | 5 | Software select code to store |
| mn_en_in | input | 1 | M/N programming enable to store |
| safe_en_in | input | 1 | Safe-reload enable to store |
| safe_code_in | input | 5 | Safe code to store |
| depth_we | input | 1 | Load the watchdog depth |
| depth_in | input | DEPTH_W | Watchdog depth to store |
| wd_we | input | 1 | Write the watchdog enable |
| wd_en_in | input | 1 | Watchdog enable value (1 restarts) |
| clk_src | input | 1 | Clock carried by the shared pin in clock mode |
| fs_code | output | 5 | Effective frequency-select code |
| strap_code | output | 5 | Frozen strap code |
| mn_mode | output | 1 | M/N programming active |
| wd_running | output | 1 | Watchdog counting |
| wd_timeout | output | 1 | Watchdog has expired |
| depth_rd | output | DEPTH_W | Live count or stored depth |
| pin_oe | output | 1 | Shared pin drive enable |
| pin_drv | output | 1 | Shared pin drive value |

## Verification
On every cycle, the assertions check the following: running and timeout are never both set; an expiry clears M/N mode, loads the right recovery code and, in reset mode, starts a low drive; the running flag falls only after a tick or an enable write; and the frozen straps never move. The bench's scenarios are needed for the rest: the exact tick on which a given depth expires, the length of the reset pulse, the priority collisions between writes and ticks, and the shared pin switching between its two functions across a second power-up.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
   localparam int CODE_W = 5;
   typedef logic [CODE_W-1:0] fs_code_t;
   localparam fs_code_t SW_CODE_RST   = 5'b00010;
   localparam fs_code_t SAFE_CODE_RST = 5'b00010;
endpackage

// File: rtl/wfg_strap.sv
module wfg_strap
   import wfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pwr_ok_n,
   input  fs_code_t strap_in,
   input  logic     mode_in,
   output fs_code_t code_q,
   output logic     mode_q,
   output logic     locked_q
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         mode_q   <= 1'b0;
         seen_q   <= 1'b0;
         locked_q <= 1'b0;
      end else if (!locked_q) begin
         if (!pwr_ok_n) begin
            code_q <= strap_in;
            mode_q <= mode_in;
            seen_q <= 1'b1;
         end else if (seen_q) begin
            locked_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wfg_wdt.sv
module wfg_wdt #(
   parameter int DEPTH_W   = 7,
   parameter int DEPTH_RST = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wd_we,
   input  logic               wd_en_in,
   input  logic               depth_we,
   input  logic [DEPTH_W-1:0] depth_in,
   output logic               running,
   output logic               timeout,
   output logic [DEPTH_W-1:0] depth_rd,
   output logic               expire
);
   localparam logic [DEPTH_W-1:0] DEPTH_INIT = DEPTH_W'(DEPTH_RST);
   localparam logic [DEPTH_W-1:0] ONE        = DEPTH_W'(1);

   logic [DEPTH_W-1:0] depth_q, cnt_q;

   assign expire   = tick & running & ~wd_we & (cnt_q <= ONE);
   assign depth_rd = running ? cnt_q : depth_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= DEPTH_INIT;
         cnt_q   <= '0;
         running <= 1'b0;
         timeout <= 1'b0;
      end else begin
         if (depth_we)
            depth_q <= depth_in;
         if (wd_we) begin
            if (wd_en_in) begin
               cnt_q   <= depth_q;
               running <= 1'b1;
               timeout <= 1'b0;
            end else begin
               running <= 1'b0;
            end
         end else if (expire) begin
            cnt_q   <= '0;
            running <= 1'b0;
            timeout <= 1'b1;
         end else if (tick && running) begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end
endmodule

// File: rtl/wfg_sel.sv
module wfg_sel
   import wfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  logic     sel_en_in,
   input  fs_code_t sw_code_in,
   input  logic     mn_en_in,
   input  logic     safe_en_in,
   input  fs_code_t safe_code_in,
   input  logic     expire,
   input  fs_code_t strap_code,
   output fs_code_t fs_code,
   output logic     mn_mode,
   output logic     safe_en_q,
   output fs_code_t safe_code_q
);
   logic     sel_en_q;
   fs_code_t sw_code_q;

   assign fs_code = sel_en_q ? sw_code_q : strap_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_en_q    <= 1'b0;
         sw_code_q   <= SW_CODE_RST;
         mn_mode     <= 1'b0;
         safe_en_q   <= 1'b0;
         safe_code_q <= SAFE_CODE_RST;
      end else if (expire) begin
         mn_mode <= 1'b0;
         if (safe_en_q) begin
            sw_code_q <= safe_code_q;
            sel_en_q  <= 1'b1;
         end else begin
            sel_en_q  <= 1'b0;
         end
      end else if (cfg_we) begin
         sel_en_q    <= sel_en_in;
         sw_code_q   <= sw_code_in;
         mn_mode     <= mn_en_in;
         safe_en_q   <= safe_en_in;
         safe_code_q <= safe_code_in;
      end
   end
endmodule

// File: rtl/wfg_pin.sv
module wfg_pin #(
   parameter int PULSE_TICKS = 1,
   parameter bit HAS_RST_PIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic expire,
   input  logic mode_q,
   input  logic clk_src,
   output logic pin_oe,
   output logic pin_drv
);
   localparam int PW = $clog2(PULSE_TICKS + 1);

   generate
      if (HAS_RST_PIN) begin : g_rst
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcnt_q <= '0;
            else if (expire && mode_q)
               pcnt_q <= PW'(PULSE_TICKS);
            else if (tick && pcnt_q != '0)
               pcnt_q <= pcnt_q - PW'(1);
         end
         assign pin_oe  = mode_q ? (pcnt_q != '0) : 1'b1;
         assign pin_drv = mode_q ? 1'b0 : clk_src;
      end else begin : g_clk
         logic unused_in;
         assign unused_in = ^{clk, rst_n, tick, expire, mode_q};
         assign pin_oe    = 1'b1;
         assign pin_drv   = clk_src;
      end
   endgenerate
endmodule

// File: rtl/wfg_guard.sv
module wfg_guard
   import wfg_pkg::*;
#(
   parameter int DEPTH_W     = 7,
   parameter int DEPTH_RST   = 8,
   parameter int PULSE_TICKS = 1,
   parameter bit HAS_RST_PIN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_ok_n,
   input  logic [4:0]         strap_fs,
   input  logic               strap_mode,
   input  logic               tick,
   input  logic               cfg_we,
   input  logic               sel_en_in,
   input  logic [4:0]         sw_code_in,
   input  logic               mn_en_in,
   input  logic               safe_en_in,
   input  logic [4:0]         safe_code_in,
   input  logic               depth_we,
   input  logic [DEPTH_W-1:0] depth_in,
   input  logic               wd_we,
   input  logic               wd_en_in,
   input  logic               clk_src,
   output logic [4:0]         fs_code,
   output logic [4:0]         strap_code,
   output logic               mn_mode,
   output logic               wd_running,
   output logic               wd_timeout,
   output logic [DEPTH_W-1:0] depth_rd,
   output logic               pin_oe,
   output logic               pin_drv
);
   generate
      if (DEPTH_W < 1 || DEPTH_W > 16) begin : g_bad_w
         $error("wfg_guard: DEPTH_W out of range");
      end
      if (DEPTH_RST < 0 || DEPTH_RST >= (1 << DEPTH_W)) begin : g_bad_rst
         $error("wfg_guard: DEPTH_RST does not fit DEPTH_W");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("wfg_guard: PULSE_TICKS must be at least 1");
      end
   endgenerate

   logic     mode_q, locked_q, expire, safe_en_q;
   fs_code_t safe_code_q;

   wfg_strap u_strap (
      .clk(clk), .rst_n(rst_n), .pwr_ok_n(pwr_ok_n),
      .strap_in(strap_fs), .mode_in(strap_mode),
      .code_q(strap_code), .mode_q(mode_q), .locked_q(locked_q)
   );

   wfg_wdt #(.DEPTH_W(DEPTH_W), .DEPTH_RST(DEPTH_RST)) u_wdt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wd_we(wd_we), .wd_en_in(wd_en_in),
      .depth_we(depth_we), .depth_in(depth_in),
      .running(wd_running), .timeout(wd_timeout),
      .depth_rd(depth_rd), .expire(expire)
   );

   wfg_sel u_sel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
      .sel_en_in(sel_en_in), .sw_code_in(sw_code_in),
      .mn_en_in(mn_en_in), .safe_en_in(safe_en_in),
      .safe_code_in(safe_code_in), .expire(expire),
      .strap_code(strap_code), .fs_code(fs_code), .mn_mode(mn_mode),
      .safe_en_q(safe_en_q), .safe_code_q(safe_code_q)
   );

   wfg_pin #(.PULSE_TICKS(PULSE_TICKS), .HAS_RST_PIN(HAS_RST_PIN)) u_pin (
      .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire),
      .mode_q(mode_q), .clk_src(clk_src),
      .pin_oe(pin_oe), .pin_drv(pin_drv)
   );
endmodule

// File: rtl/wfg_guard_chk.sv
module wfg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       wd_we,
   input logic       wd_running,
   input logic       wd_timeout,
   input logic       mn_mode,
   input logic [4:0] fs_code,
   input logic [4:0] strap_code,
   input logic       locked_q,
   input logic       mode_q,
   input logic       safe_en_q,
   input logic [4:0] safe_code_q,
   input logic       pin_oe,
   input logic       pin_drv
);
   // R5
   run_to_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wd_running && wd_timeout));

   // R6
   mn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_timeout) |-> !mn_mode);

   // R7
   recover_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_timeout) |->
         fs_code == ($past(safe_en_q) ? $past(safe_code_q) : strap_code));

   // R1
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked_q) |-> $stable(strap_code));

   // R9
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wd_timeout) && mode_q) |-> (pin_oe && !pin_drv));

   // R3
   stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_running) |-> ($past(tick) || $past(wd_we)));
endmodule

bind wfg_guard wfg_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wd_we(wd_we),
   .wd_running(wd_running), .wd_timeout(wd_timeout), .mn_mode(mn_mode),
   .fs_code(fs_code), .strap_code(strap_code), .locked_q(locked_q),
   .mode_q(mode_q), .safe_en_q(safe_en_q), .safe_code_q(safe_code_q),
   .pin_oe(pin_oe), .pin_drv(pin_drv)
);

// File: tb/wfg_guard_test.sv
module wfg_guard_test;
   localparam int CLK_P  = 10;
   localparam int DW     = 7;
   localparam int PULSES = 1;

   logic clk = 1'b0, rst_n = 1'b0, pwr_ok_n = 1'b0;
   logic [4:0] strap_fs = 5'b01010;
   logic strap_mode = 1'b1, tick = 1'b0, cfg_we = 1'b0, sel_en_in = 1'b0;
   logic [4:0] sw_code_in = '0, safe_code_in = '0;
   logic mn_en_in = 1'b0, safe_en_in = 1'b0, depth_we = 1'b0;
   logic [DW-1:0] depth_in = '0;
   logic wd_we = 1'b0, wd_en_in = 1'b0, clk_src = 1'b0;
   logic [4:0] fs_code, strap_code;
   logic mn_mode, wd_running, wd_timeout, pin_oe, pin_drv;
   logic [DW-1:0] depth_rd;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   wfg_guard uut (.*);

   // behavioural reference model
   int m_strap, m_mode, m_samp, m_lock, m_sel, m_code, m_mn, m_safe_en, m_safe;
   int m_depth, m_cnt, m_run, m_to, m_pulse;
   bit fire;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_strap = 0; m_mode = 0; m_samp = 0; m_lock = 0;
         m_sel = 0; m_code = 2; m_mn = 0; m_safe_en = 0; m_safe = 2;
         m_depth = 8; m_cnt = 0; m_run = 0; m_to = 0; m_pulse = 0;
      end else begin
         fire = 0;
         if (wd_we) begin
            if (wd_en_in) begin m_cnt = m_depth; m_run = 1; m_to = 0; end
            else m_run = 0;
         end else if (tick && m_run) begin
            if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_to = 1; fire = 1; end
            else m_cnt = m_cnt - 1;
         end
         if (depth_we) m_depth = depth_in;
         if (fire && m_mode == 1) m_pulse = PULSES;
         else if (tick && m_pulse > 0) m_pulse = m_pulse - 1;
         if (fire) begin
            m_mn = 0;
            if (m_safe_en == 1) begin m_code = m_safe; m_sel = 1; end
            else m_sel = 0;
         end else if (cfg_we) begin
            m_sel = sel_en_in; m_code = sw_code_in; m_mn = mn_en_in;
            m_safe_en = safe_en_in; m_safe = safe_code_in;
         end
         if (m_lock == 0) begin
            if (!pwr_ok_n) begin m_strap = strap_fs; m_mode = strap_mode; m_samp = 1; end
            else if (m_samp == 1) m_lock = 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 strap_code", strap_code, m_strap);
         chk("R2 fs_code", fs_code, (m_sel == 1) ? m_code : m_strap);
         chk("R6 mn_mode", mn_mode, m_mn);
         chk("R3 wd_running", wd_running, m_run);
         chk("R5 wd_timeout", wd_timeout, m_to);
         chk("R4 depth_rd", depth_rd, (m_run == 1) ? m_cnt : m_depth);
         chk("R9 pin_oe", pin_oe, (m_mode == 1) ? int'(m_pulse != 0) : 1);
         chk("R9 pin_drv", pin_drv, (m_mode == 1) ? 0 : int'(clk_src));
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_tick();
      step(); tick = 1'b1; step(); tick = 1'b0;
   endtask

   task automatic cfg(input logic sel, input logic [4:0] code, input logic mn,
                      input logic sen, input logic [4:0] sc);
      step(); cfg_we = 1'b1; sel_en_in = sel; sw_code_in = code;
      mn_en_in = mn; safe_en_in = sen; safe_code_in = sc;
      step(); cfg_we = 1'b0;
   endtask

   task automatic set_depth(input int d);
      step(); depth_we = 1'b1; depth_in = DW'(d); step(); depth_we = 1'b0;
   endtask

   task automatic wd_write(input logic en);
      step(); wd_we = 1'b1; wd_en_in = en; step(); wd_we = 1'b0;
   endtask

   task automatic powerup(input logic [4:0] s, input logic md);
      rst_n = 1'b0; pwr_ok_n = 1'b0; strap_fs = s; strap_mode = md;
      step(2); rst_n = 1'b1; step(3); pwr_ok_n = 1'b1; step(2);
   endtask

   initial begin
      // first power-up: reset-pin mode, strap 01010
      powerup(5'b01010, 1'b1);
      @(negedge clk);
      chk("R10 reset fs", fs_code, 5'b01010);
      chk("R10 reset depth", depth_rd, 8);
      chk("R10 reset running", wd_running, 0);
      strap_fs = 5'b11111; strap_mode = 1'b0; step(3);
      @(negedge clk);
      chk("R1 strap held", strap_code, 5'b01010);

      // software code with M/N on, strap fallback
      cfg(1'b1, 5'b00100, 1'b1, 1'b0, 5'b11000);
      @(negedge clk);
      chk("R2 sw code", fs_code, 5'b00100);
      set_depth(3);
      wd_write(1'b1);
      @(negedge clk);
      chk("R3 restart", depth_rd, 3);
      do_tick(); do_tick();
      @(negedge clk);
      chk("R4 count", depth_rd, 1);
      do_tick();
      @(negedge clk);
      chk("R5 timeout", wd_timeout, 1);
      chk("R6 mn cleared", mn_mode, 0);
      chk("R7 strap reload", fs_code, 5'b01010);
      chk("R9 pulse low", pin_oe, 1);
      chk("R4 depth shown", depth_rd, 3);
      do_tick();
      @(negedge clk);
      chk("R9 pulse end", pin_oe, 0);

      // safe code reload
      cfg(1'b0, 5'b00000, 1'b1, 1'b1, 5'b11000);
      wd_write(1'b1);
      @(negedge clk);
      chk("R3 timeout cleared", wd_timeout, 0);
      repeat (3) do_tick();
      @(negedge clk);
      chk("R7 safe code", fs_code, 5'b11000);

      // depth 0: immediate expiry
      set_depth(0);
      cfg(1'b0, 5'b00000, 1'b1, 1'b0, 5'b00001);
      wd_write(1'b1);
      do_tick();
      @(negedge clk);
      chk("R5 depth0", wd_timeout, 1);

      // keep-alive beats tick in the same cycle
      set_depth(2);
      wd_write(1'b1);
      do_tick();
      step(); tick = 1'b1; wd_we = 1'b1; wd_en_in = 1'b1;
      step(); tick = 1'b0; wd_we = 1'b0;
      @(negedge clk);
      chk("R8 kick wins", depth_rd, 2);

      // expiry beats a same-cycle cfg write
      cfg(1'b1, 5'b00111, 1'b1, 1'b0, 5'b00001);
      do_tick();
      step(); tick = 1'b1; cfg_we = 1'b1; sel_en_in = 1'b1; sw_code_in = 5'b10101;
      mn_en_in = 1'b1; safe_en_in = 1'b1;
      step(); tick = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      chk("R8 expiry wins mn", mn_mode, 0);
      chk("R8 expiry wins fs", fs_code, 5'b01010);

      // write 0 stops without timeout
      set_depth(5);
      wd_write(1'b1);
      wd_write(1'b0);
      repeat (6) do_tick();
      @(negedge clk);
      chk("R3 stop", wd_timeout, 0);
      chk("R3 stop run", wd_running, 0);

      // second power-up: clock mode
      powerup(5'b00101, 1'b0);
      @(negedge clk);
      chk("R1 new strap", strap_code, 5'b00101);
      clk_src = 1'b1; step();
      @(negedge clk);
      chk("R9 clock mode", pin_drv, 1);
      set_depth(1);
      wd_write(1'b1);
      do_tick();
      @(negedge clk);
      chk("R9 no pulse", pin_oe, 1);
      clk_src = 1'b0; step();
      @(negedge clk);
      chk("R9 clock low", pin_drv, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule